// File: doc/BRIEF.md
# Asynchronous DRAM Cycle Decoder

This block is a synthesizable, device-side stand-in for an asynchronous page-mode DRAM. A memory controller under test drives it as the target. The four active-low strobes (row strobe, column strobe, write enable, output enable) are sampled on a fast system clock. From the order in which the strobes change, the model works out what kind of cycle the controller started. It stores data in a small register array, keeps its own refresh row counter, and produces an output-enable for its data bus that follows each cycle type's rules for when the bus is driven.

The row address is taken when the row strobe falls. The column address passes through while the column strobe is high and is frozen when it falls. Write data is taken when write enable and the column strobe are both low for the first time, which is the later of their two falling edges. A row-strobe fall while the column strobe is already low is a refresh cycle: the row comes from the internal counter and the address bus is ignored. If the column strobe is cycled again inside that refresh, it opens an access at the counter's row, so the counter can be tested. If the row strobe is released sooner than a minimum number of clocks after it fell, the block raises a one-clock error pulse. All outputs are registered and reflect the strobes sampled at the previous clock edge.

Top module: `dram_cycle_model`

## Requirements
- R1: After reset, dout_en, cyc_type, page_acc, refresh_cnt and ras_short_err are all 0 (cyc_type 0 means idle).
- R2: For a read, the row is addr[ROW_BITS-1:0] at the ras_n fall, and the column is addr[COL_BITS-1:0] at the cas_n fall. Changes to addr while cas_n stays low are ignored. One clock after a sample with ras_n, cas_n and oe_n low and we_n high, dout_en is 1 and dout holds the stored word. cyc_type is 1 for this cycle.
- R3: dout_en returns to 0 one clock after a sample with oe_n high, cas_n high, or (during an access) we_n low.
- R4: Early write: if we_n is already low when cas_n falls, din is written at that sample and cyc_type becomes 2. dout_en stays 0 for the rest of that column cycle, and no second write happens while both strobes stay low.
- R5: Late write: if we_n falls while cas_n is low, din is written at the latched column. cyc_type becomes 4 (read-modify-write) when dout_en was 1 just before, and 3 otherwise.
- R6: Page mode: each further cas_n cycle inside one ras_n cycle accesses a new column of the latched row. page_acc is 1 for every access after the first and 0 for the first.
- R7: A ras_n cycle with cas_n held high sets cyc_type to 5, never drives the bus, and leaves the array unchanged.
- R8: ras_n falling while cas_n is low sets cyc_type to 6 and increments refresh_cnt by one, wrapping modulo 2^ROW_BITS. addr, din and we_n have no effect on the array during this cycle.
- R9: If the bus is being driven and cas_n and oe_n stay low, dout_en and dout hold through ras_n rising and through a following refresh cycle.
- R10: A cas_n high-then-low inside a refresh cycle starts a counter-test access. cyc_type becomes 8, and reads or writes use the counter value from before the increment as the row and addr as the column.
- R11: cas_n falling while ras_n is high sets cyc_type to 7. The bus stays undriven and nothing is written.
- R12: ras_short_err pulses high for one clock after a ras_n rise that follows fewer than TRAS_MIN low samples of ras_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | max(ROW_BITS,COL_BITS) | Multiplexed row/column address |
| din | input | DW | Write data |
| dout | output | DW | Read data |
| dout_en | output | 1 | Bus drive enable for dout |
| cyc_type | output | 4 | Decoded cycle type code |
| page_acc | output | 1 | Current column access is a page-mode follow-on |
| refresh_cnt | output | ROW_BITS | Internal refresh row counter (test port) |
| ras_short_err | output | 1 | Row strobe pulse shorter than TRAS_MIN |

## Verification
The bench builds the block with ROW_BITS=2, COL_BITS=2, DW=8 and TRAS_MIN=3. This gives a 16-word array, so every word can be written and read back through several cycle styles. A four-value refresh counter can be wrapped with only five refresh cycles. A three-sample pulse limit lets row-strobe widths from one to four clocks be swept across the violation threshold.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

  typedef enum logic [3:0] {
    CY_IDLE = 4'd0,
    CY_READ = 4'd1,
    CY_EWR  = 4'd2,
    CY_LWR  = 4'd3,
    CY_RMW  = 4'd4,
    CY_RFO  = 4'd5,
    CY_CBR  = 4'd6,
    CY_CASO = 4'd7,
    CY_CBRT = 4'd8
  } cyc_e;

  typedef struct packed {
    logic ras_fall;
    logic ras_rise;
    logic cas_fall;
    logic cas_rise;
    logic ras_q;
    logic cas_q;
    logic we_q;
  } strobe_t;

endpackage

// File: rtl/dcm_edge.sv
module dcm_edge
  import dcm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ras_n,
  input  logic    cas_n,
  input  logic    we_n,
  output strobe_t st
);

  logic ras_q, cas_q, we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q <= 1'b1;
      cas_q <= 1'b1;
      we_q  <= 1'b1;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      we_q  <= we_n;
    end
  end

  always_comb begin
    st.ras_fall = ras_q & ~ras_n;
    st.ras_rise = ~ras_q & ras_n;
    st.cas_fall = cas_q & ~cas_n;
    st.cas_rise = ~cas_q & cas_n;
    st.ras_q    = ras_q;
    st.cas_q    = cas_q;
    st.we_q     = we_q;
  end

endmodule

// File: rtl/dcm_seq.sv
module dcm_seq
  import dcm_pkg::*;
#(
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 5,
  parameter int TRAS_MIN = 4,
  localparam int AW = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS,
  localparam int CW = $clog2(TRAS_MIN + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  strobe_t             st,
  input  logic                ras_n,
  input  logic                cas_n,
  input  logic                we_n,
  input  logic [AW-1:0]       addr,
  input  logic                dout_en_q,
  output logic                access_ok,
  output logic                wr_en,
  output logic                ew_eff,
  output logic [ROW_BITS-1:0] row_q,
  output logic [COL_BITS-1:0] col_eff,
  output cyc_e                cyc_q,
  output logic                page_q,
  output logic [ROW_BITS-1:0] rcnt_q,
  output logic                short_q
);

  localparam logic [CW-1:0] TMIN = CW'(TRAS_MIN);

  logic                cbr_q, cbr_d, cbrt_q, cbrt_d, ew_q, ew_d;
  logic                seen_q, seen_d, page_d, short_d;
  logic [ROW_BITS-1:0] row_d, rcnt_d;
  logic [COL_BITS-1:0] col_q, col_d;
  logic [CW-1:0]       rcyc_q, rcyc_d;
  cyc_e                cyc_d;

  assign access_ok = ~ras_n & ~st.ras_q & (~cbr_q | cbrt_q);
  assign wr_en     = access_ok & ~cas_n & ~we_n & (st.cas_q | st.we_q);
  assign col_eff   = st.cas_q ? addr[COL_BITS-1:0] : col_q;
  assign ew_eff    = st.cas_q ? ~we_n : ew_q;

  always_comb begin
    cbr_d   = cbr_q;
    cbrt_d  = cbrt_q;
    ew_d    = ew_q;
    seen_d  = seen_q;
    page_d  = page_q;
    row_d   = row_q;
    rcnt_d  = rcnt_q;
    rcyc_d  = rcyc_q;
    cyc_d   = cyc_q;
    col_d   = st.cas_q ? addr[COL_BITS-1:0] : col_q;
    short_d = st.ras_rise && (rcyc_q < TMIN);

    if (st.ras_fall) begin
      cbr_d  = ~cas_n;
      cbrt_d = 1'b0;
      seen_d = 1'b0;
      page_d = 1'b0;
      rcyc_d = CW'(1);
      if (cas_n) begin
        row_d = addr[ROW_BITS-1:0];
        cyc_d = CY_RFO;
      end else begin
        row_d  = rcnt_q;
        rcnt_d = rcnt_q + ROW_BITS'(1);
        cyc_d  = CY_CBR;
      end
    end else if (~ras_n) begin
      if (rcyc_q < TMIN) rcyc_d = rcyc_q + CW'(1);
      if (cbr_q && st.cas_rise) cbrt_d = 1'b1;
    end

    if (st.cas_fall) begin
      if (ras_n) begin
        cyc_d = CY_CASO;
      end else if (access_ok) begin
        if (cbrt_q)     cyc_d = CY_CBRT;
        else if (~we_n) cyc_d = CY_EWR;
        else            cyc_d = CY_READ;
        ew_d   = ~we_n;
        page_d = seen_q;
        seen_d = 1'b1;
      end
    end

    if (st.cas_rise) ew_d = 1'b0;

    if (wr_en && ~st.cas_q) begin
      if (cbrt_q)         cyc_d = CY_CBRT;
      else if (dout_en_q) cyc_d = CY_RMW;
      else                cyc_d = CY_LWR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cbr_q   <= 1'b0;
      cbrt_q  <= 1'b0;
      ew_q    <= 1'b0;
      seen_q  <= 1'b0;
      page_q  <= 1'b0;
      row_q   <= '0;
      col_q   <= '0;
      rcnt_q  <= '0;
      rcyc_q  <= '0;
      cyc_q   <= CY_IDLE;
      short_q <= 1'b0;
    end else begin
      cbr_q   <= cbr_d;
      cbrt_q  <= cbrt_d;
      ew_q    <= ew_d;
      seen_q  <= seen_d;
      page_q  <= page_d;
      row_q   <= row_d;
      col_q   <= col_d;
      rcnt_q  <= rcnt_d;
      rcyc_q  <= rcyc_d;
      cyc_q   <= cyc_d;
      short_q <= short_d;
    end
  end

endmodule

// File: rtl/dcm_array.sv
module dcm_array #(
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 5,
  parameter int DW       = 8,
  localparam int DEPTH   = 1 << (ROW_BITS + COL_BITS)
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [ROW_BITS-1:0] row,
  input  logic [COL_BITS-1:0] col,
  input  logic [DW-1:0]       wdata,
  output logic [DW-1:0]       rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[{row, col}] <= wdata;
  end

  assign rdata = mem[{row, col}];

endmodule

// File: rtl/dram_cycle_model.sv
module dram_cycle_model
  import dcm_pkg::*;
#(
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 5,
  parameter int DW       = 8,
  parameter int TRAS_MIN = 4,
  localparam int AW = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ras_n,
  input  logic                cas_n,
  input  logic                we_n,
  input  logic                oe_n,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       din,
  output logic [DW-1:0]       dout,
  output logic                dout_en,
  output logic [3:0]          cyc_type,
  output logic                page_acc,
  output logic [ROW_BITS-1:0] refresh_cnt,
  output logic                ras_short_err
);

  strobe_t             st;
  logic                access_ok, wr_en, ew_eff, drive;
  logic [ROW_BITS-1:0] row_q;
  logic [COL_BITS-1:0] col_eff;
  logic [DW-1:0]       rdata, dout_d;
  logic                en_d;
  cyc_e                cyc_q;
  logic                unused_addr_bits;

  assign unused_addr_bits = ^addr;

  dcm_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .st    (st)
  );

  dcm_seq #(
    .ROW_BITS (ROW_BITS),
    .COL_BITS (COL_BITS),
    .TRAS_MIN (TRAS_MIN)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .addr      (addr),
    .dout_en_q (dout_en),
    .access_ok (access_ok),
    .wr_en     (wr_en),
    .ew_eff    (ew_eff),
    .row_q     (row_q),
    .col_eff   (col_eff),
    .cyc_q     (cyc_q),
    .page_q    (page_acc),
    .rcnt_q    (refresh_cnt),
    .short_q   (ras_short_err)
  );

  dcm_array #(
    .ROW_BITS (ROW_BITS),
    .COL_BITS (COL_BITS),
    .DW       (DW)
  ) u_array (
    .clk   (clk),
    .wr_en (wr_en),
    .row   (row_q),
    .col   (col_eff),
    .wdata (din),
    .rdata (rdata)
  );

  assign drive = access_ok & ~cas_n & ~oe_n & we_n & ~ew_eff;

  always_comb begin
    dout_d = dout;
    if (cas_n) begin
      en_d = 1'b0;
    end else if (drive) begin
      en_d   = 1'b1;
      dout_d = rdata;
    end else if (!access_ok) begin
      en_d = dout_en & ~oe_n;
    end else begin
      en_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_en <= 1'b0;
      dout    <= '0;
    end else begin
      dout_en <= en_d;
      dout    <= dout_d;
    end
  end

  assign cyc_type = cyc_q;

endmodule

// File: rtl/dcm_checker.sv
module dcm_checker
  import dcm_pkg::*;
#(
  parameter int ROW_BITS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ras_n,
  input logic                cas_n,
  input logic                we_n,
  input logic                oe_n,
  input logic                dout_en,
  input logic [3:0]          cyc_type,
  input logic [ROW_BITS-1:0] refresh_cnt,
  input logic                ras_short_err
);

  p_drive_needs_cas_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> $past(!cas_n));

  p_drive_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_en) |-> $past(!ras_n && we_n && !oe_n));

  p_early_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_type == 4'(CY_EWR)) |-> !dout_en);

  p_rfo_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_type == 4'(CY_RFO)) |-> !dout_en);

  p_casonly_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_type == 4'(CY_CASO)) |-> !dout_en);

  p_cnt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_cnt != $past(refresh_cnt)) |->
      ((refresh_cnt == $past(refresh_cnt) + ROW_BITS'(1)) && $past(!ras_n && !cas_n)));

  p_short_edge_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ras_short_err |-> ($past(ras_n) && !$past(ras_n, 2)));

endmodule

bind dram_cycle_model dcm_checker #(.ROW_BITS(ROW_BITS)) u_chk (.*);

// File: tb/tb_dram_cycle_model.sv
module tb_dram_cycle_model;

  localparam int RB = 2;
  localparam int CB = 2;
  localparam int DW = 8;
  localparam int TM = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ras_n, cas_n, we_n, oe_n;
  logic [1:0]    addr;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          dout_en;
  logic [3:0]    cyc_type;
  logic          page_acc;
  logic [RB-1:0] refresh_cnt;
  logic          ras_short_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  logic [DW-1:0] em [16];
  int cnt_exp = 0;

  always #10 clk = ~clk;

  dram_cycle_model #(.ROW_BITS(RB), .COL_BITS(CB), .DW(DW), .TRAS_MIN(TM)) dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .cyc_type(cyc_type),
    .page_acc(page_acc), .refresh_cnt(refresh_cnt), .ras_short_err(ras_short_err)
  );

  function automatic logic [DW-1:0] pat(input int r, input int c);
    return DW'(r * 37 + c * 11 + 5);
  endfunction

  task automatic drv(input logic r, input logic c, input logic w, input logic o,
                     input logic [1:0] a, input logic [DW-1:0] d);
    ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = a; din = d;
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle2();
    drv(1, 1, 1, 1, 0, 0);
    drv(1, 1, 1, 1, 0, 0);
  endtask

  task automatic read_word(input int r, input int c);
    drv(0, 1, 1, 1, 2'(r), 0);
    drv(0, 0, 1, 0, 2'(c), 0);
    chk("R2", "read en", 32'(dout_en), 1);
    chk("R2", "read data", 32'(dout), 32'(em[r*4+c]));
    drv(0, 0, 1, 0, 2'(c), 0);
    drv(0, 1, 1, 1, 0, 0);
    idle2();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog run did not finish");
    finish_run();
  end

  initial begin
    ras_n = 1; cas_n = 1; we_n = 1; oe_n = 1; addr = 0; din = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "dout_en", 32'(dout_en), 0);
    chk("R1", "cyc_type", 32'(cyc_type), 0);
    chk("R1", "page_acc", 32'(page_acc), 0);
    chk("R1", "refresh_cnt", 32'(refresh_cnt), 0);
    chk("R1", "ras_short_err", 32'(ras_short_err), 0);

    // Fill: even rows early write, odd rows late write, all in page mode
    for (int r = 0; r < 4; r++) begin
      drv(0, 1, 1, 1, 2'(r), 0);
      for (int c = 0; c < 4; c++) begin
        if (r % 2 == 0) begin
          drv(0, 1, 0, 1, 2'(c), 0);
          drv(0, 0, 0, 1, 2'(c), pat(r, c));
          chk("R4", "early type", 32'(cyc_type), 2);
          chk("R4", "early en", 32'(dout_en), 0);
          chk("R6", "page_acc", 32'(page_acc), (c != 0) ? 1 : 0);
          drv(0, 0, 0, 0, ~2'(c), 8'hFF);
          chk("R4", "early en oe low", 32'(dout_en), 0);
          drv(0, 1, 1, 1, 2'(c), 0);
        end else begin
          drv(0, 0, 1, 1, 2'(c), 0);
          chk("R2", "read type", 32'(cyc_type), 1);
          chk("R6", "page_acc", 32'(page_acc), (c != 0) ? 1 : 0);
          drv(0, 0, 1, 1, ~2'(c), 0);
          drv(0, 0, 0, 1, ~2'(c), pat(r, c));
          chk("R5", "late type", 32'(cyc_type), 3);
          chk("R5", "late en", 32'(dout_en), 0);
          drv(0, 1, 1, 1, 2'(c), 0);
        end
        em[r*4+c] = pat(r, c);
      end
      idle2();
    end

    // Page-mode read sweep with column latch, OE and CAS gating
    for (int r = 0; r < 4; r++) begin
      drv(0, 1, 1, 1, 2'(r), 0);
      for (int c = 0; c < 4; c++) begin
        drv(0, 0, 1, 0, 2'(c), 0);
        chk("R2", "page read en", 32'(dout_en), 1);
        chk("R2", "page read data", 32'(dout), 32'(em[r*4+c]));
        chk("R6", "read page_acc", 32'(page_acc), (c != 0) ? 1 : 0);
        drv(0, 0, 1, 0, ~2'(c), 0);
        chk("R2", "column latched", 32'(dout), 32'(em[r*4+c]));
        drv(0, 0, 1, 1, ~2'(c), 0);
        chk("R3", "oe high off", 32'(dout_en), 0);
        drv(0, 1, 1, 0, 2'(c), 0);
        chk("R3", "cas high off", 32'(dout_en), 0);
      end
      idle2();
    end

    // Read-modify-write on row 2 col 1
    drv(0, 1, 1, 1, 2, 0);
    drv(0, 0, 1, 0, 1, 0);
    chk("R5", "rmw read data", 32'(dout), 32'(em[9]));
    drv(0, 0, 0, 0, 1, 8'hA5);
    chk("R5", "rmw type", 32'(cyc_type), 4);
    chk("R3", "we low off", 32'(dout_en), 0);
    drv(0, 1, 1, 1, 0, 0);
    idle2();
    em[9] = 8'hA5;
    read_word(2, 1);

    // RAS-only refresh with WE low and data on the bus
    drv(0, 1, 0, 1, 3, 8'h00);
    chk("R7", "ror type", 32'(cyc_type), 5);
    drv(0, 1, 0, 0, 3, 8'h00);
    drv(0, 1, 0, 0, 3, 8'h00);
    chk("R7", "ror en", 32'(dout_en), 0);
    idle2();
    chk("R7", "ror cnt", 32'(refresh_cnt), 0);
    for (int c = 0; c < 4; c++) read_word(3, c);

    // CAS-only cycle
    drv(1, 0, 0, 1, 1, 8'h11);
    chk("R11", "cas-only type", 32'(cyc_type), 7);
    drv(1, 0, 1, 0, 1, 0);
    chk("R11", "cas-only en", 32'(dout_en), 0);
    idle2();
    read_word(0, 1);

    // Refresh sweep through counter wrap, WE low and junk address
    for (int k = 0; k < 5; k++) begin
      drv(1, 0, 1, 1, 0, 0);
      drv(0, 0, 0, 1, 2'(k), 8'hEE);
      cnt_exp = (cnt_exp + 1) % 4;
      chk("R8", "cbr type", 32'(cyc_type), 6);
      chk("R8", "cbr count", 32'(refresh_cnt), 32'(cnt_exp));
      drv(0, 0, 0, 1, 2'(k), 8'hEE);
      drv(0, 0, 0, 1, 2'(k), 8'hEE);
      drv(1, 0, 1, 1, 0, 0);
      idle2();
    end

    // Counter test: row comes from the counter value before the increment
    drv(1, 0, 1, 1, 0, 0);
    drv(0, 0, 1, 1, 0, 0);
    chk("R10", "test cnt", 32'(refresh_cnt), 2);
    drv(0, 1, 1, 1, 2, 0);
    drv(0, 0, 0, 1, 2, 8'h5C);
    chk("R10", "test type", 32'(cyc_type), 8);
    chk("R10", "test write en", 32'(dout_en), 0);
    drv(0, 1, 1, 1, 3, 0);
    drv(0, 0, 1, 0, 3, 0);
    chk("R10", "test read en", 32'(dout_en), 1);
    chk("R10", "test read data", 32'(dout), 32'(em[1*4+3]));
    drv(0, 1, 1, 1, 0, 0);
    idle2();
    em[1*4+2] = 8'h5C;
    read_word(1, 2);

    // Hidden refresh: output held across RAS high and refresh
    drv(0, 1, 1, 1, 3, 0);
    drv(0, 0, 1, 0, 3, 0);
    drv(0, 0, 1, 0, 0, 0);
    chk("R9", "hidden start", 32'(dout), 32'(em[15]));
    drv(1, 0, 1, 0, 0, 0);
    chk("R9", "hold ras high en", 32'(dout_en), 1);
    chk("R9", "hold ras high data", 32'(dout), 32'(em[15]));
    drv(0, 0, 1, 0, 1, 0);
    chk("R9", "hold cbr en", 32'(dout_en), 1);
    chk("R9", "hold cbr data", 32'(dout), 32'(em[15]));
    chk("R8", "hidden cnt", 32'(refresh_cnt), 3);
    drv(0, 0, 1, 0, 1, 0);
    drv(0, 0, 1, 0, 1, 0);
    chk("R9", "hold cbr later", 32'(dout_en), 1);
    drv(1, 0, 1, 0, 0, 0);
    drv(1, 1, 1, 1, 0, 0);
    chk("R3", "hidden release", 32'(dout_en), 0);
    idle2();

    // RAS pulse width sweep
    for (int n = 1; n <= 4; n++) begin
      for (int i = 0; i < n; i++) drv(0, 1, 1, 1, 0, 0);
      drv(1, 1, 1, 1, 0, 0);
      chk("R12", "short flag", 32'(ras_short_err), (n < TM) ? 1 : 0);
      drv(1, 1, 1, 1, 0, 0);
      chk("R12", "short clears", 32'(ras_short_err), 0);
    end

    // Final full readback
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) read_word(r, c);

    finish_run();
  end

endmodule